// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column-address stream of a synchronous DRAM burst engine. A mode word is captured into an internal register and decoded into a burst length, an address ordering, a read latency and a write-burst option. When a READ or WRITE command arrives with a starting column, the sequencer presents one column per clock in the programmed order. A separate strobe marks the clocks on which read data would be returned once the programmed latency has passed.

A controller loads the mode word once and then issues commands. A burst of 2, 4 or 8 stays inside the aligned block that holds its starting column and wraps inside that block. A full-page burst steps through the whole page until the stop input ends it. A new command always replaces the burst in progress. The sequencer is built around a three-state machine. SEQ_IDLE presents nothing. SEQ_BURST runs a burst of fixed length. SEQ_PAGE runs an open-ended full-page burst. The transitions are as follows. The accept transition goes from any state to SEQ_BURST or SEQ_PAGE when a command meets a legal mode. The done transition goes from SEQ_BURST to SEQ_IDLE after the last beat. The stop transition goes from SEQ_BURST or SEQ_PAGE to SEQ_IDLE when the stop input is high and no command arrives.

Top module: `sdram_col_seq`

## Requirements
- R1: On a clock edge with `mode_load` high, `mode_word` is stored and decoded. Bits [2:0] set the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives a full page. Bit 3 selects the ordering: 0 is sequential, 1 is interleaved. Bits [6:4] set the read latency: 010 gives 2, 011 gives 3. Bit 9 is the write-single option. Bits 8:7 are ignored. A command on the same edge uses the previous mode.
- R2: Any other length code or latency code raises `mode_illegal`. While that flag is high, a command starts no burst and `col_valid` stays low.
- R3: A command accepted on edge n presents its first column from edge n onward. A new column follows on each later edge. `col_valid` stays high for exactly the burst length. `col_write` copies the command's write bit.
- R4: In a sequential burst of length L, the low log2(L) bits of the column count up modulo L from the start value. The upper bits are held, so a burst of 8 from column 13 runs 13,14,15,8,9,10,11,12.
- R5: In an interleaved burst, the low bits are the start value XOR the beat index, so a burst of 8 from 5 runs 5,4,7,6,1,0,3,2.
- R6: A full-page burst counts up from any starting column, wraps from column PAGE_COLS-1 to 0, and runs until `burst_stop`.
- R7: When the full-page length is combined with interleaved ordering, `mode_order_err` goes high and the burst is run in sequential order.
- R8: With bit 9 set, every write is a single beat, while reads keep the programmed length.
- R9: `rd_data_valid` is high exactly m clocks after each read beat, where m is the latency programmed when that read was accepted. Write beats never raise it.
- R10: A command that arrives during a burst cuts that burst short, and the new burst's first column appears on the same edge. `burst_stop` with no command ends any burst on that edge.
- R11: After reset, `col_valid` and `rd_data_valid` are low, and the mode register holds zero, which is an illegal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Store `mode_word` into the mode register |
| mode_word | input | 10 | Mode word (fields in R1) |
| cmd_valid | input | 1 | READ or WRITE command strobe |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Starting column of the command |
| burst_stop | input | 1 | End the current burst |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | `col_addr` carries a burst beat |
| col_write | output | 1 | The current beat belongs to a write |
| rd_data_valid | output | 1 | Read data would be on the bus this clock |
| mode_illegal | output | 1 | The stored mode holds an unsupported code |
| mode_order_err | output | 1 | Full page combined with interleaved ordering |

## Verification
The bench targets the points where a wrap or an XOR is easily mishandled. One is a sequential burst starting in the middle of an aligned block: a design that forgot to hold the upper bits would leave the block. Another is an interleaved burst from an odd start: a design that added instead of XOR-ing would repeat the sequential order. A full-page burst crossing the last column must come back to 0, and an off-by-one design would leave the page or stall. Truncation, stop and write-single cases expose a design that drops or adds a beat. Latency 2 and 3 reads expose a strobe delay line tapped at the wrong stage. Illegal codes expose a design that starts a burst anyway.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

    // Mode word layout: the positions are decoded by the sequencer
    localparam int MODE_W      = 10;
    localparam int LEN_LSB     = 0;
    localparam int ORDER_BIT   = 3;
    localparam int LAT_LSB     = 4;
    localparam int WSINGLE_BIT = 9;
    localparam int BLK_W       = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BURST = 2'd1,
        SEQ_PAGE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             legal;
        logic             page;
        logic [BLK_W-1:0] len_m1;
        logic             intl;
        logic             lat3;
        logic             wr_single;
        logic             order_err;
    } burst_cfg_t;

endpackage

// File: rtl/cseq_mode_dec.sv
module cseq_mode_dec
    import col_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       len_ok;
    logic       lat_ok;
    logic       unused_reserved;

    assign unused_reserved = ^mode_word[8:7];

    always_comb begin
        len_code = mode_word[LEN_LSB +: 3];
        lat_code = mode_word[LAT_LSB +: 3];
        cfg      = '0;
        len_ok   = 1'b1;
        case (len_code)
            3'b000:  cfg.len_m1 = 3'd0;
            3'b001:  cfg.len_m1 = 3'd1;
            3'b010:  cfg.len_m1 = 3'd3;
            3'b011:  cfg.len_m1 = 3'd7;
            3'b111:  cfg.page   = 1'b1;
            default: len_ok     = 1'b0;
        endcase
        lat_ok        = (lat_code == 3'b010) || (lat_code == 3'b011);
        cfg.lat3      = (lat_code == 3'b011);
        cfg.intl      = mode_word[ORDER_BIT] && !cfg.page;
        cfg.order_err = mode_word[ORDER_BIT] && cfg.page;
        cfg.wr_single = mode_word[WSINGLE_BIT];
        cfg.legal     = len_ok && lat_ok;
    end

endmodule

// File: rtl/cseq_addr_gen.sv
module cseq_addr_gen
    import col_seq_pkg::*;
#(
    parameter  int PAGE_COLS = 1024,
    localparam int COL_W     = $clog2(PAGE_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] start_col,
    input  logic [BLK_W-1:0] len_m1,
    input  logic             intl,
    input  logic             page,
    output logic [COL_W-1:0] col,
    output logic             last
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_COLS - 1);

    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] page_col_q;
    logic [BLK_W-1:0] mask_q;
    logic [BLK_W-1:0] cnt_q;
    logic             intl_q;
    logic             page_q;

    logic [BLK_W-1:0] low;
    logic [COL_W-1:0] mask_ext;
    logic [COL_W-1:0] burst_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            page_col_q <= '0;
            mask_q     <= '0;
            cnt_q      <= '0;
            intl_q     <= 1'b0;
            page_q     <= 1'b0;
        end else if (load) begin
            start_q    <= start_col;
            page_col_q <= start_col;
            mask_q     <= len_m1;
            cnt_q      <= '0;
            intl_q     <= intl;
            page_q     <= page;
        end else if (step) begin
            cnt_q      <= cnt_q + 1'b1;
            page_col_q <= (page_col_q == LAST_COL) ? '0 : page_col_q + 1'b1;
        end
    end

    always_comb begin
        mask_ext  = {{(COL_W-BLK_W){1'b0}}, mask_q};
        low       = intl_q ? (start_q[BLK_W-1:0] ^ cnt_q)
                           : (start_q[BLK_W-1:0] + cnt_q);
        low       = low & mask_q;
        burst_col = (start_q & ~mask_ext) | {{(COL_W-BLK_W){1'b0}}, low};
        col       = page_q ? page_col_q : burst_col;
        last      = (cnt_q == mask_q);
    end

endmodule

// File: rtl/cseq_lat_line.sv
module cseq_lat_line (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_rd,
    input  logic beat_lat3,
    output logic rd_valid
);

    localparam int DEPTH = 3;

    logic [DEPTH-1:0] v_q;
    logic [DEPTH-1:0] l3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            l3_q <= '0;
        end else begin
            v_q  <= {v_q[DEPTH-2:0], beat_rd};
            l3_q <= {l3_q[DEPTH-2:0], beat_lat3};
        end
    end

    // stage k holds a beat seen k+1 clocks ago
    assign rd_valid = (v_q[1] && !l3_q[1]) || (v_q[2] && l3_q[2]);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import col_seq_pkg::*;
#(
    parameter  int PAGE_COLS = 1024,
    localparam int COL_W     = $clog2(PAGE_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_write,
    output logic              rd_data_valid,
    output logic              mode_illegal,
    output logic              mode_order_err
);

    logic [MODE_W-1:0] mode_q;
    burst_cfg_t        cfg;
    seq_state_e        st_q;
    seq_state_e        st_d;
    logic              accept;
    logic              single;
    logic              ag_step;
    logic              ag_last;
    logic              lat3_q;
    logic              col_write_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (mode_load) mode_q <= mode_word;
    end

    cseq_mode_dec u_dec (
        .mode_word (mode_q),
        .cfg       (cfg)
    );

    assign accept = cmd_valid && cfg.legal;
    assign single = cmd_write && cfg.wr_single;

    cseq_addr_gen #(.PAGE_COLS(PAGE_COLS)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (ag_step),
        .start_col (cmd_col),
        .len_m1    (single ? 3'd0 : cfg.len_m1),
        .intl      (cfg.intl),
        .page      (cfg.page && !single),
        .col       (col_addr),
        .last      (ag_last)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:  st_d = SEQ_IDLE;
            SEQ_BURST: if (burst_stop || ag_last) st_d = SEQ_IDLE;
            SEQ_PAGE:  if (burst_stop) st_d = SEQ_IDLE;
            default:   st_d = SEQ_IDLE;
        endcase
        if (accept) st_d = (cfg.page && !single) ? SEQ_PAGE : SEQ_BURST;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // burst attributes captured at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_write_q <= 1'b0;
            lat3_q      <= 1'b0;
        end else if (accept) begin
            col_write_q <= cmd_write;
            lat3_q      <= cfg.lat3;
        end
    end

    // outputs
    always_comb begin
        col_valid = 1'b0;
        ag_step   = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                col_valid = 1'b0;
                ag_step   = 1'b0;
            end
            SEQ_BURST, SEQ_PAGE: begin
                col_valid = 1'b1;
                ag_step   = 1'b1;
            end
            default: begin
                col_valid = 1'b0;
                ag_step   = 1'b0;
            end
        endcase
        col_write      = col_write_q;
        mode_illegal   = !cfg.legal;
        mode_order_err = cfg.order_err;
    end

    cseq_lat_line u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_rd   (col_valid && !col_write_q),
        .beat_lat3 (lat3_q),
        .rd_valid  (rd_data_valid)
    );

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk
    import col_seq_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int PAGE_COLS = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             burst_stop,
    input logic             col_valid,
    input logic             rd_data_valid,
    input logic             mode_illegal,
    input logic [COL_W-1:0] col_addr,
    input seq_state_e       st_q
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_COLS - 1);

    AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> $past(cmd_valid)); // R3

    AST_ILLEGAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_illegal && cmd_valid && !col_valid) |=> !col_valid); // R2

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_PAGE && !cmd_valid && !burst_stop) |=>
        (col_addr == (($past(col_addr) == LAST_COL) ? '0 : COL_W'($past(col_addr) + 1'b1)))); // R6

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_valid && col_valid) |=> !col_valid); // R10

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(col_valid, 2) && !$past(col_valid, 3)) |-> !rd_data_valid); // R9

endmodule

bind sdram_col_seq cseq_chk #(.COL_W(COL_W), .PAGE_COLS(PAGE_COLS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .burst_stop    (burst_stop),
    .col_valid     (col_valid),
    .rd_data_valid (rd_data_valid),
    .mode_illegal  (mode_illegal),
    .col_addr      (col_addr),
    .st_q          (st_q)
);

// File: tb/tb_sdram_col_seq.sv
`timescale 1ns/1ps
module tb_sdram_col_seq;

    localparam int PAGE  = 1024;
    localparam int COL_W = 10;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             wr;
        logic             lat3;
    } beat_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_load;
    logic [9:0]       mode_word;
    logic             cmd_valid;
    logic             cmd_write;
    logic [COL_W-1:0] cmd_col;
    logic             burst_stop;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_write;
    logic             rd_data_valid;
    logic             mode_illegal;
    logic             mode_order_err;

    sdram_col_seq #(.PAGE_COLS(PAGE)) dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_write(col_write), .rd_data_valid(rd_data_valid),
        .mode_illegal(mode_illegal), .mode_order_err(mode_order_err)
    );

    always #10 clk = ~clk;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    mon_on = 0;
    string g_tag = "R3";
    beat_t sb[$];
    bit    exp_rd[int];

    int g_len = 1;
    bit g_page = 0;
    bit g_intl = 0;
    bit g_lat3 = 0;
    bit g_ws = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_col(input int start, input int len, input bit intl,
                                   input bit pg, input int k);
        int m;
        int lo;
        if (pg) return (start + k) % PAGE;
        m  = len - 1;
        lo = intl ? ((start & m) ^ k) : ((start + k) & m);
        return (start & ~m) | lo;
    endfunction

    function automatic logic [9:0] mw(input bit ws, input int lat, input bit intl, input int bl);
        return {ws, 2'b00, 3'(lat), intl, 3'(bl)};
    endfunction

    // monitor: pops expected beats and checks the read strobe timing
    always @(negedge clk) begin
        beat_t b;
        if (mon_on) begin
            if (col_valid) begin
                if (sb.size() == 0) begin
                    chk(0, {g_tag, " unexpected beat"}, int'(col_addr), -1);
                end else begin
                    b = sb.pop_front();
                    chk(col_addr == b.col, {g_tag, " column"}, int'(col_addr), int'(b.col));
                    chk(col_write == b.wr, "R3 write flag", int'(col_write), int'(b.wr));
                    if (!b.wr) exp_rd[cyc + (b.lat3 ? 3 : 2)] = 1'b1;
                end
            end
            chk(rd_data_valid == exp_rd.exists(cyc), "R9 read strobe",
                int'(rd_data_valid), int'(exp_rd.exists(cyc)));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic load_mode(input bit ws, input int lat, input bit intl, input int bl);
        mode_word = mw(ws, lat, intl, bl);
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        @(negedge clk);
        g_ws   = ws;
        g_intl = intl;
        g_lat3 = (lat == 3);
        g_page = (bl == 7);
        case (bl)
            0: g_len = 1;
            1: g_len = 2;
            2: g_len = 4;
            3: g_len = 8;
            default: g_len = 1;
        endcase
    endtask

    // driver: pushes the expected beats, then drives the command for one cycle
    task automatic do_cmd(input int col, input bit wr, input int n);
        bit pg;
        int len;
        int cnt;
        pg  = g_page && !(wr && g_ws);
        len = (wr && g_ws) ? 1 : g_len;
        cnt = (n < 0) ? len : n;
        for (int k = 0; k < cnt; k++) begin
            beat_t b;
            b.col  = COL_W'(exp_col(col, len, g_intl && !pg, pg, k));
            b.wr   = wr;
            b.lat3 = g_lat3;
            sb.push_back(b);
        end
        cmd_col   = COL_W'(col);
        cmd_write = wr;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stop_pulse();
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; cmd_valid = 1'b0;
        cmd_write = 1'b0; cmd_col = '0; burst_stop = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(col_valid == 0, "R11 col_valid after reset", int'(col_valid), 0);
        chk(rd_data_valid == 0, "R11 rd_data_valid after reset", int'(rd_data_valid), 0);
        chk(mode_illegal == 1, "R11 zero mode is illegal", int'(mode_illegal), 1);
        mon_on = 1;

        // R2 command with illegal mode is ignored
        g_tag = "R2";
        do_cmd(5, 0, 0);
        repeat (3) @(negedge clk);
        chk(col_valid == 0, "R2 no burst on illegal mode", int'(col_valid), 0);
        settle();

        // R1 decode: BL8 sequential, latency 2
        load_mode(0, 2, 0, 3);
        chk(mode_illegal == 0, "R1 legal mode accepted", int'(mode_illegal), 0);
        chk(mode_order_err == 0, "R1 no order error", int'(mode_order_err), 0);
        g_tag = "R4";
        do_cmd(13, 0, -1);
        settle();

        // R5 interleaved BL8, latency 3
        load_mode(0, 3, 1, 3);
        g_tag = "R5";
        do_cmd(5, 0, -1);
        settle();

        // R4 sequential BL4 write near top of page
        load_mode(0, 2, 0, 2);
        g_tag = "R4";
        do_cmd(1014, 1, -1);
        settle();

        // R5 interleaved BL4 read
        load_mode(0, 3, 1, 2);
        g_tag = "R5";
        do_cmd(9, 0, -1);
        settle();

        // R5 interleaved BL2 and R4 sequential BL2
        load_mode(0, 2, 1, 1);
        g_tag = "R5";
        do_cmd(7, 0, -1);
        settle();
        load_mode(0, 2, 0, 1);
        g_tag = "R4";
        do_cmd(6, 0, -1);
        settle();

        // R3 burst of one
        load_mode(0, 3, 0, 0);
        g_tag = "R3";
        do_cmd(100, 0, -1);
        settle();

        // R6 full page crossing the last column, stopped after 6 beats
        load_mode(0, 3, 0, 7);
        chk(mode_order_err == 0, "R6 sequential page no error", int'(mode_order_err), 0);
        g_tag = "R6";
        do_cmd(1022, 0, 6);
        repeat (5) @(negedge clk);
        stop_pulse();
        settle();

        // R7 full page with interleaved request runs sequentially
        load_mode(0, 2, 1, 7);
        chk(mode_order_err == 1, "R7 order error flagged", int'(mode_order_err), 1);
        chk(mode_illegal == 0, "R7 still legal", int'(mode_illegal), 0);
        g_tag = "R7";
        do_cmd(40, 1, 3);
        repeat (2) @(negedge clk);
        stop_pulse();
        settle();

        // R8 write-single option
        load_mode(1, 2, 0, 3);
        g_tag = "R8";
        do_cmd(3, 1, -1);
        settle();
        do_cmd(3, 0, -1);
        settle();

        // R10 truncation by a new command after 3 beats
        load_mode(0, 2, 0, 3);
        g_tag = "R10";
        do_cmd(0, 0, 3);
        repeat (2) @(negedge clk);
        do_cmd(20, 0, -1);
        settle();

        // R10 stop input ends a fixed burst after 2 beats
        do_cmd(50, 1, 2);
        repeat (1) @(negedge clk);
        stop_pulse();
        settle();

        // R2 illegal latency and illegal length codes
        load_mode(0, 4, 0, 3);
        chk(mode_illegal == 1, "R2 latency code 100 illegal", int'(mode_illegal), 1);
        g_tag = "R2";
        do_cmd(8, 0, 0);
        settle();
        load_mode(0, 2, 0, 4);
        chk(mode_illegal == 1, "R2 length code 100 illegal", int'(mode_illegal), 1);
        do_cmd(8, 1, 0);
        settle();

        chk(sb.size() == 0, "R3 all expected beats seen", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule